// File: doc/BRIEF.md
# Four-Channel Synchronised DAC Register Bank

This block is the host-facing register file in front of four 12-bit digital-to-analog converter channels. The host writes a code for each channel and a shared byte that holds a 2-bit output span for every channel. In synchronous mode, channel writes fill holding registers only. A separate strobe write then moves all four held codes to the output latches on one clock edge, so the converters change together. In immediate mode, each channel write reaches its output latch directly.

The mode lives in a small state machine with three states:
- **DIRECT**: immediate mode.
- **SYNC_CLEAN**: synchronous mode, every output latch equal to its holding register.
- **SYNC_PEND**: synchronous mode, at least one held code not yet published.

The transitions are:
- *arm* (DIRECT to SYNC_CLEAN): a sync-control write with bit 0 set.
- *stage* (SYNC_CLEAN to SYNC_PEND): a channel data write.
- *publish* (SYNC_PEND to SYNC_CLEAN): a strobe write.
- *release* (either sync state to DIRECT): a sync-control write with bit 0 clear. Release also copies every held code to the outputs.

All other events leave the state unchanged. The span byte and the mode bit are readable on a combinational read port.

Top module: `dacbank_top`

## Requirements
- R1: After reset, every channel output code is 0x800, the span byte is 0xAA, and synchronous mode is on (the sync-control readback is 1).
- R2: A write to address 2n (n = 0..3) targets channel n. Only wr_data[11:0] is used; bits 15:12 are discarded.
- R3: In synchronous mode, a channel write updates only the holding register, and no output code changes.
- R4: A write of any data to address 9 copies all four holding registers to the outputs on the following clock edge.
- R5: In immediate mode, a channel write changes that channel's output code on the following clock edge.
- R6: A write to address 8 loads wr_data[7:0] as the span byte on the next edge, in either mode. Channel n uses bits 2n+1:2n: 0 = 0..5 V, 1 = 0..10 V, 2 = ±5 V, 3 = ±10 V. rd_addr 8 returns the byte in rd_data[7:0], with the upper bits zero.
- R7: Bit 0 of a write to address 15 sets the mode (1 = synchronous), and its other bits are ignored. rd_addr 15 returns the mode in rd_data[0], with the upper bits zero.
- R8: A write to address 15 with bit 0 clear, made while in synchronous mode, copies all holding registers to the outputs on that same edge.
- R9: Writes to addresses 1, 3, 5, 7 and 10 to 14 change nothing. Reads at any address other than 8 and 15 return 0.
- R10: When wr_en is low, nothing changes, whatever is on wr_addr and wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| dac_code | output | 48 | Output codes, channel n at bits 12n+11:12n |
| dac_range | output | 8 | Span byte, channel n at bits 2n+1:2n |

## Verification
The bench goes after five corner cases, each with its own failure symptom:
- Outputs that move on a synchronous-mode data write: a strobe that leaks through, which the bench sees as an output code changing before any strobe.
- A strobe that copies only some channels: one converter left on its old code.
- A mode release that does not flush pending codes: outputs stuck on stale values after switching to immediate mode.
- Span fields shifted or crossed between channels: the wrong span on a channel, which a sweep of all 256 span bytes exposes.
- Partial address decoding: writes to odd or high unmapped addresses aliasing onto a data, span or sync register.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
    typedef enum logic [1:0] {
        ST_DIRECT     = 2'd0,
        ST_SYNC_CLEAN = 2'd1,
        ST_SYNC_PEND  = 2'd2
    } sync_state_e;

    localparam logic [3:0] ADDR_SPAN   = 4'd8;
    localparam logic [3:0] ADDR_STROBE = 4'd9;
    localparam logic [3:0] ADDR_MODE   = 4'd15;
endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode #(
    parameter int NCH = 4,
    parameter int AW  = 4
) (
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    output logic [NCH-1:0] chan_wr,
    output logic           span_wr,
    output logic           strobe_wr,
    output logic           mode_wr
);
    import dacbank_pkg::*;

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        assign chan_wr[n] = wr_en && (wr_addr == AW'(2 * n));
    end

    assign span_wr   = wr_en && (wr_addr == AW'(ADDR_SPAN));
    assign strobe_wr = wr_en && (wr_addr == AW'(ADDR_STROBE));
    assign mode_wr   = wr_en && (wr_addr == AW'(ADDR_MODE));
endmodule

// File: rtl/dacbank_mode_fsm.sv
module dacbank_mode_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic any_chan_wr,
    input  logic strobe_wr,
    input  logic mode_wr,
    input  logic mode_bit,
    output dacbank_pkg::sync_state_e state,
    output logic load_all,
    output logic direct
);
    import dacbank_pkg::*;

    sync_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DIRECT: begin
                if (mode_wr && mode_bit) state_d = ST_SYNC_CLEAN;          // arm
            end
            ST_SYNC_CLEAN: begin
                if (mode_wr && !mode_bit) state_d = ST_DIRECT;             // release
                else if (any_chan_wr)     state_d = ST_SYNC_PEND;          // stage
            end
            ST_SYNC_PEND: begin
                if (mode_wr && !mode_bit) state_d = ST_DIRECT;             // release
                else if (strobe_wr)       state_d = ST_SYNC_CLEAN;         // publish
            end
            default: state_d = ST_SYNC_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SYNC_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        direct   = (state_q == ST_DIRECT);
        load_all = strobe_wr || (mode_wr && !mode_bit && (state_q != ST_DIRECT));
    end

    assign state = state_q;

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_DIRECT, ST_SYNC_CLEAN, ST_SYNC_PEND}); // R7
    AST_STAGE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DIRECT && any_chan_wr) |=> state_q == ST_SYNC_PEND); // R3
    AST_RELEASE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !mode_bit) |=> state_q == ST_DIRECT); // R7
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_we,
    input  logic          direct,
    input  logic          load_all,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] code_out,
    output logic [DW-1:0] hold_out
);
    localparam logic [DW-1:0] MID_CODE = DW'(1) << (DW - 1);

    logic [DW-1:0] hold_q, out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= MID_CODE;
            out_q  <= MID_CODE;
        end else begin
            if (hold_we) hold_q <= wdata;
            if (load_all)                out_q <= hold_q;
            else if (hold_we && direct)  out_q <= wdata;
        end
    end

    assign code_out = out_q;
    assign hold_out = hold_q;

    AST_SYNC_NO_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && !load_all) |=> $stable(out_q)); // R3
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        load_all |=> out_q == $past(hold_q)); // R4
    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (direct && hold_we && !load_all) |=> out_q == $past(wdata)); // R5
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top #(
    parameter int NCH    = 4,
    parameter int DW     = 12,
    parameter int AW     = 4,
    parameter int BUS_W  = 16,
    parameter logic [2*NCH-1:0] SPAN_RESET = 8'hAA
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [BUS_W-1:0]   rd_data,
    output logic [NCH*DW-1:0]  dac_code,
    output logic [2*NCH-1:0]   dac_range
);
    import dacbank_pkg::*;

    localparam int SPAN_W = 2 * NCH;

    logic [NCH-1:0] chan_wr;
    logic           span_wr, strobe_wr, mode_wr;
    logic           load_all, direct;
    sync_state_e    state;
    logic [SPAN_W-1:0] span_q;
    logic [NCH*DW-1:0] hold_flat;

    dacbank_decode #(.NCH(NCH), .AW(AW)) u_decode (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .chan_wr   (chan_wr),
        .span_wr   (span_wr),
        .strobe_wr (strobe_wr),
        .mode_wr   (mode_wr)
    );

    dacbank_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_chan_wr (|chan_wr),
        .strobe_wr   (strobe_wr),
        .mode_wr     (mode_wr),
        .mode_bit    (wr_data[0]),
        .state       (state),
        .load_all    (load_all),
        .direct      (direct)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dacbank_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_we  (chan_wr[n]),
            .direct   (direct),
            .load_all (load_all),
            .wdata    (wr_data[DW-1:0]),
            .code_out (dac_code[n*DW +: DW]),
            .hold_out (hold_flat[n*DW +: DW])
        );

        AST_CLEAN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (state != ST_SYNC_PEND) |-> dac_code[n*DW +: DW] == hold_flat[n*DW +: DW]); // R8
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       span_q <= SPAN_RESET;
        else if (span_wr) span_q <= wr_data[SPAN_W-1:0];
    end

    assign dac_range = span_q;

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_SPAN))      rd_data = BUS_W'(span_q);
        else if (rd_addr == AW'(ADDR_MODE)) rd_data = BUS_W'(state != ST_DIRECT);
    end

    AST_SPAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !span_wr |=> $stable(span_q)); // R9
    AST_SPAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        span_wr |=> span_q == $past(wr_data[SPAN_W-1:0])); // R6
    AST_MODE_READ_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == AW'(ADDR_MODE)) |-> rd_data[BUS_W-1:1] == '0); // R7
endmodule

// File: tb/sim_dacbank_top.sv
`timescale 1ns/1ps
module sim_dacbank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [47:0] dac_code;
    logic [7:0]  dac_range;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [11:0] hold_m [4];
    logic [11:0] out_m  [4];
    logic [7:0]  span_m;
    logic        sync_m;

    always #4 clk = ~clk;

    dacbank_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dac_code(dac_code), .dac_range(dac_range)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int ch = 0; ch < 4; ch++)
            chk(req, $sformatf("code ch%0d", ch), 32'(dac_code[ch*12 +: 12]), 32'(out_m[ch]));
        chk(req, "range port", 32'(dac_range), 32'(span_m));
    endtask

    task automatic check_reads(input string req);
        rd_addr = 4'd8;  #1;
        chk(req, "span readback", 32'(rd_data), 32'(span_m));
        rd_addr = 4'd15; #1;
        chk(req, "mode readback", 32'(rd_data), 32'(sync_m));
    endtask

    // Applies one bus write and updates the model from the requirements.
    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic en = 1'b1);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en) begin
            if (a < 4'd8 && a[0] == 1'b0) begin                 // R2
                hold_m[a[2:1]] = d[11:0];
                if (!sync_m) out_m[a[2:1]] = d[11:0];           // R5
            end else if (a == 4'd8) begin
                span_m = d[7:0];                                // R6
            end else if (a == 4'd9) begin
                for (int ch = 0; ch < 4; ch++) out_m[ch] = hold_m[ch]; // R4
            end else if (a == 4'd15) begin
                if (!d[0] && sync_m)                            // R8
                    for (int ch = 0; ch < 4; ch++) out_m[ch] = hold_m[ch];
                sync_m = d[0];                                  // R7
            end
        end
    endtask

    initial begin
        for (int ch = 0; ch < 4; ch++) begin hold_m[ch] = 12'h800; out_m[ch] = 12'h800; end
        span_m = 8'hAA; sync_m = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        check_reads("R1");

        // R3 / R2: synchronous writes with junk in the upper bits
        for (int ch = 0; ch < 4; ch++) begin
            wr(4'(2*ch), 16'hF000 | 16'(12'h0AB + ch*12'h111));
            check_all("R3");
        end
        wr(4'd9, 16'h1234);
        check_all("R4");
        chk("R2", "ch3 masked code", 32'(dac_code[36 +: 12]), 32'(12'h0AB + 3*12'h111));

        // R6: full sweep of the span byte, per-field arithmetic
        for (int v = 0; v < 256; v++) begin
            wr(4'd8, 16'hFF00 | 16'(v));
            for (int ch = 0; ch < 4; ch++)
                chk("R6", $sformatf("span field ch%0d", ch),
                    32'(dac_range[2*ch +: 2]), 32'((v >> (2*ch)) & 3));
            check_reads("R6");
        end

        // R9: unmapped writes and reads
        for (int a = 0; a < 16; a++) begin
            if ((a[0] && a != 9 && a != 15) || (a >= 10 && a <= 14)) begin
                wr(4'(a), 16'hFFFF);
                check_all("R9");
                check_reads("R9");
                rd_addr = 4'(a); #1;
                chk("R9", $sformatf("read addr %0d", a), 32'(rd_data), 32'h0);
            end
        end
        for (int a = 0; a < 8; a += 2) begin
            rd_addr = 4'(a); #1;
            chk("R9", $sformatf("read data addr %0d", a), 32'(rd_data), 32'h0);
        end

        // R10: disabled write
        wr(4'd0, 16'h0123, 1'b0);
        wr(4'd15, 16'h0000, 1'b0);
        check_all("R10");
        check_reads("R10");

        // R8: pending codes flushed when leaving synchronous mode
        wr(4'd4, 16'h0F0F);
        wr(4'd6, 16'h0001);
        check_all("R3");
        wr(4'd15, 16'hFFFE);
        check_all("R8");
        check_reads("R7");

        // R5: immediate mode sweep
        for (int k = 0; k < 16; k++)
            for (int ch = 0; ch < 4; ch++) begin
                wr(4'(2*ch), 16'((k*273 + ch*17) & 12'hFFF));
                chk("R5", $sformatf("direct ch%0d", ch),
                    32'(dac_code[ch*12 +: 12]), 32'((k*273 + ch*17) & 12'hFFF));
            end
        wr(4'd0, 16'h0FFF); check_all("R5");
        wr(4'd2, 16'h0000); check_all("R5");

        // R7: only bit 0 selects the mode
        wr(4'd15, 16'hFFFE); check_reads("R7");
        wr(4'd15, 16'h0003); check_reads("R7");
        wr(4'd2, 16'h0555);  check_all("R3");
        wr(4'd9, 16'h0000);  check_all("R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule